// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block prepares the display DMA channels for each new frame. On a frame-start strobe it clears every channel's source address, then visits the channels in ascending index order. For each enabled channel it picks a descriptor address, either the channel's linked next-descriptor pointer or a one-shot branch address that software has armed. It then reads a four-word descriptor over a request/valid memory port and stores the words in that channel's registers. Only descriptor addresses inside one of two legal memory windows are fetched.

After each enabled channel's fetch stage, the block checks the channel's frame source address. If the address is zero or lies outside the legal windows, the block pulses a per-channel bus-error event. A one-shot branch pulses a per-channel branch event when its interrupt flag is set. A done pulse marks the end of the scan. Software reads all per-channel state through a flat register port. Software can write only the descriptor pointer and the branch register.

Top module: `desc_chain_fetcher`

## Requirements
- R1: After reset, every register reads zero, `busy_o` is low, and no event, done or memory request is active.
- R2: Per-channel words sit at 0x200 + 16*ch: next pointer at +0, source at +4, frame ID at +8, command at +0xC. A write to +0 stores the data with bits 3:0 cleared. Writes to +4, +8 and +0xC are ignored.
- R3: The branch register of channel ch sits at 0x100 + 4*ch. Bit 0 arms a branch and bit 1 requests a branch event. A write keeps only the bits of mask 0xFFFFFFF3.
- R4: A one-cycle `frame_start_i` while idle clears the source word of every channel. Each enabled channel whose descriptor is fetched then stores the words read at pointer +0, +4, +8 and +0xC as next pointer, source, ID and command. The command word is kept whole, including the length field in bits 20:2 and the palette-load flag in bit 26.
- R5: `busy_o` rises the cycle after an accepted frame start. `done_o` pulses once, for one cycle, after the highest channel is handled, and the block then returns to idle. A frame start that arrives while busy is ignored.
- R6: A descriptor is fetched only if its 16 bytes lie wholly within [W0_BASE, W0_BASE+W0_SIZE) or within [W1_BASE, W1_BASE+W1_SIZE). Otherwise no memory request is made, and the channel's next pointer, ID and command stay unchanged.
- R7: If branch bit 0 is set when a channel is visited, the descriptor address is branch bits 31:4 with the low nibble zero. Bit 0 then clears while the other bits stay, and the channel's branch event pulses if bit 1 is set. A disarmed branch register has no effect on later frames.
- R8: A channel whose enable bit is low is skipped. It makes no memory request and raises no event, and its registers other than the source word keep their values.
- R9: After each enabled channel's fetch stage, a bus-error event pulses for that channel if its source word is zero or lies outside both windows. For source addresses the window upper bound is inclusive (base+size is legal).
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i` is seen. Each valid beat delivers one 32-bit word, so a fetched descriptor takes exactly four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start_i | input | 1 | One-cycle frame-start strobe |
| ch_en_i | input | NCH | Per-channel enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data word |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| branch_evt_o | output | NCH | Per-channel branch event pulse |
| bus_err_evt_o | output | NCH | Per-channel bus-error event pulse |

## Verification
The assertions assume three things about the environment. `mem_valid_i` is high only while a request is pending. Software does not write a channel's branch register in the cycle that the sequencer consumes it. Frame-start strobes last one cycle. The bench memory model raises valid only in response to a visible request. All register writes happen while the block is idle, with one exception: an extra frame-start pulse is issued mid-scan on purpose to show that it is ignored. The descriptor and source addresses are placed on both sides of each window edge to exercise the range checks.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int WORD_W = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * 4;
  localparam logic [WORD_W-1:0] NEXT_WR_MASK = 32'hFFFF_FFF0;
  localparam logic [WORD_W-1:0] BRA_WR_MASK  = 32'hFFFF_FFF3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_FETCH,
    S_CHECK,
    S_NEXT
  } seq_state_e;
endpackage

// File: rtl/fdf_win_chk.sv
module fdf_win_chk
  import fdf_pkg::*;
#(
  parameter logic [WORD_W-1:0] W0_BASE = 32'h0000_1000,
  parameter logic [WORD_W-1:0] W0_SIZE = 32'h0000_0400,
  parameter logic [WORD_W-1:0] W1_BASE = 32'h0000_8000,
  parameter logic [WORD_W-1:0] W1_SIZE = 32'h0000_0100,
  parameter int SPAN = 0
) (
  input  logic [WORD_W-1:0] addr_i,
  output logic              ok_o
);
  localparam logic [WORD_W:0] LO0 = {1'b0, W0_BASE};
  localparam logic [WORD_W:0] LO1 = {1'b0, W1_BASE};
  localparam logic [WORD_W:0] HI0 = {1'b0, W0_BASE} + {1'b0, W0_SIZE} - (WORD_W+1)'(SPAN);
  localparam logic [WORD_W:0] HI1 = {1'b0, W1_BASE} + {1'b0, W1_SIZE} - (WORD_W+1)'(SPAN);

  logic [WORD_W:0] a_ext;

  always_comb begin
    a_ext = {1'b0, addr_i};
    ok_o  = ((a_ext >= LO0) && (a_ext <= HI0)) ||
            ((a_ext >= LO1) && (a_ext <= HI1));
  end
endmodule

// File: rtl/fdf_chan_regs.sv
module fdf_chan_regs
  import fdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_next_i,
  input  logic              wr_bra_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              clr_src_i,
  input  logic              clr_bra_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] ld_next_i,
  input  logic [WORD_W-1:0] ld_src_i,
  input  logic [WORD_W-1:0] ld_id_i,
  input  logic [WORD_W-1:0] ld_cmd_i,
  output logic [WORD_W-1:0] next_o,
  output logic [WORD_W-1:0] src_o,
  output logic [WORD_W-1:0] id_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] bra_o
);
  logic [WORD_W-1:0] next_q, src_q, id_q, cmd_q, bra_q;
  logic [WORD_W-1:0] next_d, src_d, id_d, cmd_d, bra_d;
  logic              next_en, src_en, info_en, bra_en;

  always_comb begin
    next_en = load_i || wr_next_i;
    next_d  = load_i ? ld_next_i : (wdata_i & NEXT_WR_MASK);
    src_en  = load_i || clr_src_i;
    src_d   = load_i ? ld_src_i : '0;
    info_en = load_i;
    id_d    = ld_id_i;
    cmd_d   = ld_cmd_i;
    bra_en  = clr_bra_i || wr_bra_i;
    bra_d   = clr_bra_i ? {bra_q[WORD_W-1:1], 1'b0} : (wdata_i & BRA_WR_MASK);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      src_q  <= '0;
      id_q   <= '0;
      cmd_q  <= '0;
      bra_q  <= '0;
    end else begin
      if (next_en) next_q <= next_d;
      if (src_en)  src_q  <= src_d;
      if (info_en) begin
        id_q  <= id_d;
        cmd_q <= cmd_d;
      end
      if (bra_en)  bra_q  <= bra_d;
    end
  end

  assign next_o = next_q;
  assign src_o  = src_q;
  assign id_o   = id_q;
  assign cmd_o  = cmd_q;
  assign bra_o  = bra_q;
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
#(
  parameter int NCH  = 7,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              sel_en_i,
  input  logic [WORD_W-1:0] sel_next_i,
  input  logic [WORD_W-5:0] sel_bra_addr_i,
  input  logic              sel_bra_arm_i,
  input  logic              sel_bra_int_i,
  input  logic [WORD_W-1:0] sel_src_i,
  input  logic              desc_ok_i,
  input  logic              src_ok_i,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [CH_W-1:0]   cur_ch_o,
  output logic [WORD_W-1:0] ptr_cand_o,
  output logic              clr_all_o,
  output logic              clr_bra_o,
  output logic              bra_evt_o,
  output logic              berr_o,
  output logic              load_o,
  output logic [WORD_W-1:0] w_next_o,
  output logic [WORD_W-1:0] w_src_o,
  output logic [WORD_W-1:0] w_id_o,
  output logic [WORD_W-1:0] w_cmd_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);
  localparam logic [1:0]      LAST_BEAT = 2'(DESC_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [1:0]        beat_q, beat_d;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic [WORD_W-1:0] w0_q, w0_d, w1_q, w1_d, w2_q, w2_d;

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    beat_d     = beat_q;
    ptr_d      = ptr_q;
    w0_d       = w0_q;
    w1_d       = w1_q;
    w2_d       = w2_q;
    clr_all_o  = 1'b0;
    clr_bra_o  = 1'b0;
    bra_evt_o  = 1'b0;
    berr_o     = 1'b0;
    load_o     = 1'b0;
    mem_req_o  = 1'b0;
    done_o     = 1'b0;
    ptr_cand_o = sel_bra_arm_i ? {sel_bra_addr_i, 4'h0} : sel_next_i;
    unique case (state_q)
      S_IDLE: begin
        if (frame_start_i) begin
          clr_all_o = 1'b1;
          ch_d      = '0;
          state_d   = S_SEL;
        end
      end
      S_SEL: begin
        if (!sel_en_i) begin
          state_d = S_NEXT;
        end else begin
          clr_bra_o = sel_bra_arm_i;
          bra_evt_o = sel_bra_arm_i && sel_bra_int_i;
          if (desc_ok_i) begin
            ptr_d   = ptr_cand_o;
            beat_d  = '0;
            state_d = S_FETCH;
          end else begin
            state_d = S_CHECK;
          end
        end
      end
      S_FETCH: begin
        mem_req_o = 1'b1;
        if (mem_valid_i) begin
          unique case (beat_q)
            2'd0:    w0_d = mem_rdata_i;
            2'd1:    w1_d = mem_rdata_i;
            2'd2:    w2_d = mem_rdata_i;
            default: ;
          endcase
          if (beat_q == LAST_BEAT) begin
            load_o  = 1'b1;
            state_d = S_CHECK;
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      S_CHECK: begin
        berr_o  = (sel_src_i == '0) || !src_ok_i;
        state_d = S_NEXT;
      end
      S_NEXT: begin
        if (ch_q == LAST_CH) begin
          done_o  = 1'b1;
          state_d = S_IDLE;
        end else begin
          ch_d    = ch_q + 1'b1;
          state_d = S_SEL;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
      beat_q  <= '0;
      ptr_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      beat_q  <= beat_d;
      ptr_q   <= ptr_d;
      w0_q    <= w0_d;
      w1_q    <= w1_d;
      w2_q    <= w2_d;
    end
  end

  assign cur_ch_o   = ch_q;
  assign w_next_o   = w0_q;
  assign w_src_o    = w1_q;
  assign w_id_o     = w2_q;
  assign w_cmd_o    = mem_rdata_i;
  assign mem_addr_o = ptr_q + {{(WORD_W-4){1'b0}}, beat_q, 2'b00};
  assign busy_o     = (state_q != S_IDLE);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_start_only_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> $past(frame_start_i));

  assert_done_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/desc_chain_fetcher.sv
module desc_chain_fetcher
  import fdf_pkg::*;
#(
  parameter int NCH    = 7,
  parameter int REG_AW = 12,
  parameter logic [WORD_W-1:0] W0_BASE = 32'h0000_1000,
  parameter logic [WORD_W-1:0] W0_SIZE = 32'h0000_0400,
  parameter logic [WORD_W-1:0] W1_BASE = 32'h0000_8000,
  parameter logic [WORD_W-1:0] W1_SIZE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NCH-1:0]    branch_evt_o,
  output logic [NCH-1:0]    bus_err_evt_o
);
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CH_BASE = 'h200;
  localparam int CH_STEP = 16;
  localparam int BR_BASE = 'h100;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [WORD_W-1:0] next_a [NCH];
  logic [WORD_W-1:0] src_a  [NCH];
  logic [WORD_W-1:0] id_a   [NCH];
  logic [WORD_W-1:0] cmd_a  [NCH];
  logic [WORD_W-1:0] bra_a  [NCH];
  logic [CH_W-1:0]   cur_ch;
  logic [WORD_W-1:0] ptr_cand, w_next, w_src, w_id, w_cmd;
  logic [WORD_W-1:0] sel_bra;
  logic              clr_all, clr_bra, bra_evt, berr, load;
  logic              desc_ok, src_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_next_c, wr_bra_c, sel_c;
    assign wr_next_c = reg_wr_i && (reg_addr_i == REG_AW'(CH_BASE + CH_STEP*c));
    assign wr_bra_c  = reg_wr_i && (reg_addr_i == REG_AW'(BR_BASE + 4*c));
    assign sel_c     = (cur_ch == CH_W'(c));

    fdf_chan_regs u_regs (
      .clk       (clk),
      .rst_ni    (rst_ni),
      .wr_next_i (wr_next_c),
      .wr_bra_i  (wr_bra_c),
      .wdata_i   (reg_wdata_i),
      .clr_src_i (clr_all),
      .clr_bra_i (clr_bra && sel_c),
      .load_i    (load && sel_c),
      .ld_next_i (w_next),
      .ld_src_i  (w_src),
      .ld_id_i   (w_id),
      .ld_cmd_i  (w_cmd),
      .next_o    (next_a[c]),
      .src_o     (src_a[c]),
      .id_o      (id_a[c]),
      .cmd_o     (cmd_a[c]),
      .bra_o     (bra_a[c])
    );

    assert_branch_disarms_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      branch_evt_o[c] |=> !bra_a[c][0]);
  end

  assign sel_bra = bra_a[cur_ch];

  fdf_win_chk #(.W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE), .W1_BASE(W1_BASE),
                .W1_SIZE(W1_SIZE), .SPAN(DESC_BYTES)) u_desc_win (
    .addr_i (ptr_cand),
    .ok_o   (desc_ok)
  );

  fdf_win_chk #(.W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE), .W1_BASE(W1_BASE),
                .W1_SIZE(W1_SIZE), .SPAN(0)) u_src_win (
    .addr_i (src_a[cur_ch]),
    .ok_o   (src_ok)
  );

  fdf_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
    .clk            (clk),
    .rst_ni         (rst_ni),
    .frame_start_i  (frame_start_i),
    .sel_en_i       (ch_en_i[cur_ch]),
    .sel_next_i     (next_a[cur_ch]),
    .sel_bra_addr_i (sel_bra[WORD_W-1:4]),
    .sel_bra_arm_i  (sel_bra[0]),
    .sel_bra_int_i  (sel_bra[1]),
    .sel_src_i      (src_a[cur_ch]),
    .desc_ok_i      (desc_ok),
    .src_ok_i       (src_ok),
    .mem_valid_i    (mem_valid_i),
    .mem_rdata_i    (mem_rdata_i),
    .cur_ch_o       (cur_ch),
    .ptr_cand_o     (ptr_cand),
    .clr_all_o      (clr_all),
    .clr_bra_o      (clr_bra),
    .bra_evt_o      (bra_evt),
    .berr_o         (berr),
    .load_o         (load),
    .w_next_o       (w_next),
    .w_src_o        (w_src),
    .w_id_o         (w_id),
    .w_cmd_o        (w_cmd),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  assign branch_evt_o  = bra_evt ? (NCH'(1) << cur_ch) : '0;
  assign bus_err_evt_o = berr    ? (NCH'(1) << cur_ch) : '0;

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr_i == REG_AW'(CH_BASE + CH_STEP*c))      reg_rdata_o = next_a[c];
      if (reg_addr_i == REG_AW'(CH_BASE + CH_STEP*c + 4))  reg_rdata_o = src_a[c];
      if (reg_addr_i == REG_AW'(CH_BASE + CH_STEP*c + 8))  reg_rdata_o = id_a[c];
      if (reg_addr_i == REG_AW'(CH_BASE + CH_STEP*c + 12)) reg_rdata_o = cmd_a[c];
      if (reg_addr_i == REG_AW'(BR_BASE + 4*c))            reg_rdata_o = bra_a[c];
    end
  end

  assert_one_err_at_a_time_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(bus_err_evt_o));

  assert_events_idle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_o |-> (branch_evt_o == '0 && bus_err_evt_o == '0 && !mem_req_o));
endmodule

// File: tb/tb_desc_chain_fetcher.sv
module tb_desc_chain_fetcher;
  localparam int NCH = 7;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frame_start;
  logic [NCH-1:0]  ch_en;
  logic            reg_wr;
  logic [11:0]     reg_addr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic            mem_req;
  logic [31:0]     mem_addr;
  logic            mem_valid;
  logic [31:0]     mem_rdata;
  logic            busy, done;
  logic [NCH-1:0]  br_evt, be_evt;

  logic [31:0] mem [320];
  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;
  int beat_cnt = 0;
  int be_cnt [NCH];
  int br_cnt [NCH];
  int be_snap [NCH];
  int br_snap [NCH];
  int beat_snap;
  int cyc = 0;

  always #5 clk = ~clk;

  desc_chain_fetcher dut (
    .clk (clk), .rst_n (rst_n), .frame_start_i (frame_start), .ch_en_i (ch_en),
    .reg_wr_i (reg_wr), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata), .mem_req_o (mem_req), .mem_addr_o (mem_addr),
    .mem_valid_i (mem_valid), .mem_rdata_i (mem_rdata), .busy_o (busy),
    .done_o (done), .branch_evt_o (br_evt), .bus_err_evt_o (be_evt)
  );

  function automatic int midx(logic [31:0] a);
    if (a >= 32'h1000 && a < 32'h1400) return int'((a - 32'h1000) >> 2);
    if (a >= 32'h8000 && a < 32'h8100) return 256 + int'((a - 32'h8000) >> 2);
    return -1;
  endfunction

  function automatic logic [31:0] a_ptr(int c);   return 32'h1000 + 32'(c) * 32'h20; endfunction
  function automatic logic [31:0] b_ptr(int c);   return 32'h1100 + 32'(c) * 32'h20; endfunction
  function automatic logic [31:0] a_src(int c);   return 32'h1200 + 32'(c) * 32'h4;  endfunction
  function automatic logic [31:0] b_src(int c);   return 32'h80A0 + 32'(c) * 32'h10; endfunction
  function automatic logic [31:0] a_id(int c);    return 32'hA0 + 32'(c); endfunction
  function automatic logic [31:0] b_id(int c);    return 32'hB0 + 32'(c); endfunction
  function automatic logic [31:0] a_cmd(int c);
    return 32'h0010_0000 | (32'(c) << 2) | (((c % 2) == 1) ? 32'h0400_0000 : 32'h0);
  endfunction
  function automatic logic [31:0] b_cmd(int c);   return 32'(c) << 4; endfunction

  task automatic put_desc(logic [31:0] a, logic [31:0] n, logic [31:0] s,
                          logic [31:0] i, logic [31:0] c);
    mem[midx(a)]      = n;
    mem[midx(a + 4)]  = s;
    mem[midx(a + 8)]  = i;
    mem[midx(a + 12)] = c;
  endtask

  // memory model: valid follows a visible request, one word per beat
  always @(negedge clk) begin
    cyc++;
    mem_valid = mem_req;
    mem_rdata = (midx(mem_addr) >= 0) ? mem[midx(mem_addr)] : 32'hBAD0_BAD0;
    if (done) done_cnt++;
    if (mem_req && mem_valid) beat_cnt++;
    for (int c = 0; c < NCH; c++) begin
      if (be_evt[c]) be_cnt[c]++;
      if (br_evt[c]) br_cnt[c]++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_ch(string req, int c, logic [31:0] n, logic [31:0] s,
                        logic [31:0] i, logic [31:0] k);
    logic [31:0] v;
    rd(12'(32'h200 + 16*c),      v); chk(req, v, n);
    rd(12'(32'h200 + 16*c + 4),  v); chk(req, v, s);
    rd(12'(32'h200 + 16*c + 8),  v); chk(req, v, i);
    rd(12'(32'h200 + 16*c + 12), v); chk(req, v, k);
  endtask

  task automatic run_frame(bit extra_start);
    int d0;
    for (int c = 0; c < NCH; c++) begin
      be_snap[c] = be_cnt[c];
      br_snap[c] = br_cnt[c];
    end
    beat_snap = beat_cnt;
    d0 = done_cnt;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    if (extra_start) begin
      repeat (5) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R5 single done per frame", 32'(done_cnt - d0), 32'd1);
    chk("R5 idle after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    while (cyc < 100000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 320; i++) mem[i] = 32'h0;
    for (int c = 0; c < NCH; c++) begin
      be_cnt[c] = 0; br_cnt[c] = 0;
      put_desc(a_ptr(c), b_ptr(c), a_src(c), a_id(c), a_cmd(c));
      put_desc(b_ptr(c), a_ptr(c), b_src(c), b_id(c), b_cmd(c));
    end
    put_desc(32'h1300, a_ptr(2), 32'h1280, 32'hC2, 32'h5);
    put_desc(32'h1340, a_ptr(4), 32'h1284, 32'hC4, 32'h0);
    put_desc(32'h13F0, a_ptr(1), 32'h0,    32'hD1, 32'h1);
    put_desc(32'h80F0, a_ptr(6), 32'h1401, 32'hD6, 32'h2);

    rst_n = 1'b0; frame_start = 1'b0; ch_en = '1;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_valid = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy low", {31'd0, busy}, 32'd0);
    chk("R1 no request", {31'd0, mem_req}, 32'd0);
    for (int c = 0; c < NCH; c++) begin
      chk_ch("R1 channel regs zero", c, 0, 0, 0, 0);
      rd(12'(32'h100 + 4*c), v); chk("R1 branch zero", v, 0);
    end

    // R2 / R3 register masks and read-only words
    for (int c = 0; c < NCH; c++) wr(12'(32'h200 + 16*c), a_ptr(c) | 32'hF);
    for (int c = 0; c < NCH; c++) begin
      rd(12'(32'h200 + 16*c), v); chk("R2 next pointer masked", v, a_ptr(c));
    end
    wr(12'h204, 32'hDEAD_BEEF); wr(12'h208, 32'h1234_5678); wr(12'h20C, 32'hFFFF_FFFF);
    chk_ch("R2 read-only words ignore writes", 0, a_ptr(0), 0, 0, 0);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); chk("R3 branch write mask", v, 32'hFFFF_FFF3);
    wr(12'h100, 32'h0);

    // R4 / R10 frame 1: all channels load the A descriptors
    run_frame(0);
    chk("R10 four beats per descriptor", 32'(beat_cnt - beat_snap), 32'd28);
    for (int c = 0; c < NCH; c++) begin
      chk_ch("R4 descriptor words stored in order", c, b_ptr(c), a_src(c), a_id(c), a_cmd(c));
      chk("R9 no bus error for legal source", 32'(be_cnt[c] - be_snap[c]), 0);
    end

    // R5 / R9 frame 2 with ignored mid-scan start; source at inclusive window top
    run_frame(1);
    for (int c = 0; c < NCH; c++) begin
      chk_ch("R4 chained fetch", c, a_ptr(c), b_src(c), b_id(c), b_cmd(c));
      chk("R9 window top inclusive", 32'(be_cnt[c] - be_snap[c]), 0);
    end

    // R7 branches: ch2 armed with event, ch4 armed without
    wr(12'h108, 32'h0000_1303);
    wr(12'h110, 32'h0000_1341);
    run_frame(0);
    chk_ch("R7 branch target ch2", 2, a_ptr(2), 32'h1280, 32'hC2, 32'h5);
    chk_ch("R7 branch target ch4", 4, a_ptr(4), 32'h1284, 32'hC4, 32'h0);
    chk_ch("R7 unbranched ch0", 0, b_ptr(0), a_src(0), a_id(0), a_cmd(0));
    chk("R7 branch event ch2", 32'(br_cnt[2] - br_snap[2]), 1);
    chk("R7 no event without bit1", 32'(br_cnt[4] - br_snap[4]), 0);
    rd(12'h108, v); chk("R7 arm bit cleared ch2", v, 32'h0000_1302);
    rd(12'h110, v); chk("R7 arm bit cleared ch4", v, 32'h0000_1340);

    // R7 one shot: next frame follows the linked pointers
    run_frame(0);
    chk_ch("R7 one-shot ch2", 2, b_ptr(2), a_src(2), a_id(2), a_cmd(2));
    chk_ch("R7 one-shot ch4", 4, b_ptr(4), a_src(4), a_id(4), a_cmd(4));
    chk_ch("R7 others chained", 0, a_ptr(0), b_src(0), b_id(0), b_cmd(0));
    chk("R7 no repeat event", 32'(br_cnt[2] - br_snap[2]), 0);

    // R8 disabled channels 2 and 5
    ch_en = 7'b1011011;
    run_frame(0);
    chk_ch("R8 disabled ch2 kept", 2, b_ptr(2), 0, a_id(2), a_cmd(2));
    chk_ch("R8 disabled ch5 kept", 5, a_ptr(5), 0, b_id(5), b_cmd(5));
    chk_ch("R8 enabled ch0 loaded", 0, b_ptr(0), a_src(0), a_id(0), a_cmd(0));
    chk_ch("R8 enabled ch4 loaded", 4, a_ptr(4), b_src(4), b_id(4), b_cmd(4));
    chk("R8 fewer beats", 32'(beat_cnt - beat_snap), 32'd20);
    chk("R8 no error ch2", 32'(be_cnt[2] - be_snap[2]), 0);
    chk("R8 no error ch5", 32'(be_cnt[5] - be_snap[5]), 0);

    // R6 / R9 window edges for descriptors and sources
    ch_en = '1;
    wr(12'h200, 32'h0000_1400);
    wr(12'h210, 32'h0000_13F0);
    wr(12'h220, a_ptr(2));
    wr(12'h230, 32'h0000_0000);
    wr(12'h240, 32'h0000_8100);
    wr(12'h250, a_ptr(5));
    wr(12'h260, 32'h0000_80F0);
    run_frame(0);
    chk_ch("R6 past window end ch0", 0, 32'h1400, 0, a_id(0), a_cmd(0));
    chk_ch("R6 zero pointer ch3", 3, 32'h0, 0, a_id(3), a_cmd(3));
    chk_ch("R6 past window1 end ch4", 4, 32'h8100, 0, b_id(4), b_cmd(4));
    chk_ch("R6 last legal slot ch1", 1, a_ptr(1), 32'h0, 32'hD1, 32'h1);
    chk_ch("R6 last legal slot ch6", 6, a_ptr(6), 32'h1401, 32'hD6, 32'h2);
    chk_ch("R6 legal ch2", 2, b_ptr(2), a_src(2), a_id(2), a_cmd(2));
    chk("R10 beats for four fetches", 32'(beat_cnt - beat_snap), 32'd16);
    chk("R9 error skipped fetch ch0", 32'(be_cnt[0] - be_snap[0]), 1);
    chk("R9 error zero source ch1", 32'(be_cnt[1] - be_snap[1]), 1);
    chk("R9 no error ch2", 32'(be_cnt[2] - be_snap[2]), 0);
    chk("R9 error skipped fetch ch3", 32'(be_cnt[3] - be_snap[3]), 1);
    chk("R9 error skipped fetch ch4", 32'(be_cnt[4] - be_snap[4]), 1);
    chk("R9 no error ch5", 32'(be_cnt[5] - be_snap[5]), 0);
    chk("R9 error source past window ch6", 32'(be_cnt[6] - be_snap[6]), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule